// File: doc/BRIEF.md
# Read-Sequence Command Detector

This block watches the access stream of a byte-wide memory with a 15-bit address. It picks out two commands that are hidden in ordinary read traffic. Each access is presented for one clock with a valid strobe, the address and a write flag. A command is a run of six consecutive reads. The first five addresses are the same for both commands, and the sixth address chooses between a store request and a recall request. When a command is recognised, the block raises the matching request output for exactly one clock. A higher-level controller takes that pulse, moves the data and times the nonvolatile operation.

Any write, or any read of an address other than the one expected next, breaks the run. A read of the first prefix address also counts as the first step of a new attempt, so a restart is never lost. After the sixth access the matcher always returns to idle, whatever address that access carried. Clocks without a valid access leave the match state untouched.

Top module: `accessSeqDetector`

## Requirements
- R1: While reset is held and in the first clock after its release, both `storeReq` and `recallReq` are 0 and the matcher is idle.
- R2: Six valid reads with low address bits 0x0E38, 0x31C7, 0x03E0, 0x3C1F, 0x303F, 0x0FC0, in that order, raise `storeReq` in the clock after the sixth read is sampled.
- R3: The same five-read prefix followed by a read of 0x0C63 raises `recallReq` in the clock after the sixth read is sampled.
- R4: A valid access with `accWrite` = 1 at any step, including the sixth, produces no request and returns the matcher to idle.
- R5: A read of an address other than the expected next one aborts the run. If that read is at 0x0E38 it counts as the first step of a new run.
- R6: Two reads of the same prefix address in a row abort the run. The one exception is the first address, whose repeat restarts the run at its first step.
- R7: Address bit 14 is ignored. Only bits 13..0 are compared.
- R8: A sixth read at any address other than 0x0FC0 or 0x0C63, including 0x339C, produces no request. After any sixth access the matcher is idle, so a following read of 0x0E38 starts the run over.
- R9: Clocks with `accValid` = 0 neither advance nor abort the run.
- R10: Each request is high for one clock only, and the two requests are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| accValid | input | 1 | One access is presented this clock |
| accAddr | input | 15 | Access address |
| accWrite | input | 1 | 1 = write access, 0 = read access |
| storeReq | output | 1 | One-clock store command pulse |
| recallReq | output | 1 | One-clock recall command pulse |

## Verification
A request is registered once: it appears in the clock that follows the rising edge that samples the sixth read, and it is gone one clock later. The bench drives every access on a falling edge. It checks both outputs at the next falling edge, which is exactly one register stage later. It also checks them again during idle gaps. A behavioural model in the bench predicts the outputs for each access. It covers directed runs of aborts, restarts, bit 14 and final addresses, and then a long biased random stream compared every clock.

// File: rtl/accessSeqPkg.sv
`timescale 1ns/1ps
package accessSeqPkg;
  localparam int KEY_W      = 14;
  localparam int PREFIX_LEN = 5;
  localparam int STEP_W     = 3;
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(PREFIX_LEN);
  localparam logic [KEY_W-1:0] STORE_KEY  = 14'h0FC0;
  localparam logic [KEY_W-1:0] RECALL_KEY = 14'h0C63;

  // comparison results, datapath -> control
  typedef struct packed {
    logic hitStep;
    logic hitFirst;
    logic hitStore;
    logic hitRecall;
  } seqCmp_t;

  // strobes, control -> datapath
  typedef struct packed {
    logic [STEP_W-1:0] stepSel;
    logic fireStore;
    logic fireRecall;
  } ctlStrobe_t;

  function automatic logic [KEY_W-1:0] prefixKey(input int idx);
    case (idx)
      0:       return 14'h0E38;
      1:       return 14'h31C7;
      2:       return 14'h03E0;
      3:       return 14'h3C1F;
      4:       return 14'h303F;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/seqDatapath.sv
`timescale 1ns/1ps
module seqDatapath
  import accessSeqPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [KEY_W-1:0] keyAddr,
  input  ctlStrobe_t       ctl,
  output seqCmp_t          cmp,
  output logic             storeReq,
  output logic             recallReq
);
  localparam int PAD_W = (1 << STEP_W) - PREFIX_LEN;

  logic [PREFIX_LEN-1:0]    stepHit;
  logic [(1<<STEP_W)-1:0]   stepHitPad;

  for (genvar g = 0; g < PREFIX_LEN; g++) begin : gKey
    assign stepHit[g] = (keyAddr == prefixKey(g));
  end

  assign stepHitPad = {{PAD_W{1'b0}}, stepHit};

  always_comb begin
    cmp.hitStep   = stepHitPad[ctl.stepSel];
    cmp.hitFirst  = stepHit[0];
    cmp.hitStore  = (keyAddr == STORE_KEY);
    cmp.hitRecall = (keyAddr == RECALL_KEY);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      storeReq  <= 1'b0;
      recallReq <= 1'b0;
    end else begin
      storeReq  <= ctl.fireStore;
      recallReq <= ctl.fireRecall;
    end
  end

  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({storeReq, recallReq})); // R10
  AST_STORE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    storeReq |=> !storeReq); // R10
  AST_RECALL_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    recallReq |=> !recallReq); // R10
endmodule

// File: rtl/seqControl.sv
`timescale 1ns/1ps
module seqControl
  import accessSeqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       accValid,
  input  logic       accWrite,
  input  seqCmp_t    cmp,
  output ctlStrobe_t ctl
);
  logic [STEP_W-1:0] stepIdx;
  logic [STEP_W-1:0] stepNext;
  logic              isRead;

  assign isRead = accValid && !accWrite;

  always_comb begin
    stepNext       = stepIdx;
    ctl.stepSel    = stepIdx;
    ctl.fireStore  = 1'b0;
    ctl.fireRecall = 1'b0;
    if (accValid) begin
      if (stepIdx == LAST_STEP) begin
        ctl.fireStore  = isRead && cmp.hitStore;
        ctl.fireRecall = isRead && cmp.hitRecall;
        stepNext       = '0;
      end else if (isRead && cmp.hitStep) begin
        stepNext = stepIdx + 1'b1;
      end else if (isRead && cmp.hitFirst) begin
        stepNext = STEP_W'(1);
      end else begin
        stepNext = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stepIdx <= '0;
    else       stepIdx <= stepNext;
  end

  AST_WRITE_ABORTS: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && accWrite) |=> (stepIdx == '0)); // R4
  AST_GAP_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !accValid |=> $stable(stepIdx)); // R9
  AST_FINAL_IDLES: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && stepIdx == LAST_STEP) |=> (stepIdx == '0)); // R8
  AST_STEP_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    stepIdx <= LAST_STEP); // R5
  AST_FIRE_ON_READ: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.fireStore || ctl.fireRecall) |-> (isRead && stepIdx == LAST_STEP)); // R2
endmodule

// File: rtl/accessSeqDetector.sv
`timescale 1ns/1ps
module accessSeqDetector
  import accessSeqPkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accValid,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              accWrite,
  output logic              storeReq,
  output logic              recallReq
);
  seqCmp_t    cmp;
  ctlStrobe_t ctl;
  logic [ADDR_W-KEY_W-1:0] unusedAddrHi;

  assign unusedAddrHi = accAddr[ADDR_W-1:KEY_W];

  seqControl u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .accValid (accValid),
    .accWrite (accWrite),
    .cmp      (cmp),
    .ctl      (ctl)
  );

  seqDatapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .keyAddr   (accAddr[KEY_W-1:0]),
    .ctl       (ctl),
    .cmp       (cmp),
    .storeReq  (storeReq),
    .recallReq (recallReq)
  );

  AST_REQ_NEEDS_READ: assert property (@(posedge clk) disable iff (!rstN)
    (storeReq || recallReq) |-> $past(accValid && !accWrite)); // R4
endmodule

// File: tb/accessSeqDetector_tb.sv
`timescale 1ns/1ps
module accessSeqDetector_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        accValid = 1'b0;
  logic [14:0] accAddr = '0;
  logic        accWrite = 1'b0;
  logic        storeReq, recallReq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural reference state
  int  progress = 0;
  bit  expStore = 0;
  bit  expRecall = 0;
  int  keyList[5] = '{'h0E38, 'h31C7, 'h03E0, 'h3C1F, 'h303F};

  always #4 clk = ~clk;

  accessSeqDetector u_dut (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accAddr(accAddr),
    .accWrite(accWrite), .storeReq(storeReq), .recallReq(recallReq)
  );

  task automatic checkOut(input string tag);
    checks++;
    if (storeReq !== expStore || recallReq !== expRecall) begin
      errors++;
      $display("FAIL %s: store/recall actual %b%b expected %b%b",
               tag, storeReq, recallReq, expStore, expRecall);
    end
  endtask

  task automatic modelStep(input int a, input bit wr);
    int k;
    k = a & 'h3FFF;
    expStore = 0; expRecall = 0;
    if (progress == 5) begin
      expStore  = !wr && k == 'h0FC0;
      expRecall = !wr && k == 'h0C63;
      progress  = 0;
    end else if (!wr && k == keyList[progress]) progress++;
    else if (!wr && k == 'h0E38) progress = 1;
    else progress = 0;
  endtask

  // drive at falling edge, check one register stage later
  task automatic doAcc(input int a, input bit wr, input string tag);
    accValid = 1'b1; accAddr = 15'(a); accWrite = wr;
    modelStep(a, wr);
    @(negedge clk);
    accValid = 1'b0; accWrite = 1'b0;
    checkOut(tag);
  endtask

  task automatic idleCyc(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      expStore = 0; expRecall = 0;
      @(negedge clk);
      checkOut(tag);
    end
  endtask

  task automatic prefix(input int hi, input string tag);
    for (int i = 0; i < 5; i++) doAcc(keyList[i] | hi, 0, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checkOut("R1 in reset");
    rstN = 1'b1;
    @(negedge clk);
    checkOut("R1 after reset");

    prefix(0, "R2 prefix");
    doAcc('h0FC0, 0, "R2 store");
    idleCyc(1, "R10 store pulse ends");

    prefix(0, "R3 prefix");
    doAcc('h0C63, 0, "R3 recall");
    idleCyc(1, "R10 recall pulse ends");

    // write at step 3 with right address
    doAcc('h0E38, 0, "R4"); doAcc('h31C7, 0, "R4");
    doAcc('h03E0, 1, "R4 write abort");
    doAcc('h3C1F, 0, "R4"); doAcc('h303F, 0, "R4");
    doAcc('h0FC0, 0, "R4 no store");
    // write as sixth access
    prefix(0, "R4 prefix");
    doAcc('h0FC0, 1, "R4 write sixth");
    prefix(0, "R4 after write");
    doAcc('h0C63, 0, "R4 idle then recall");

    // wrong address aborts, then restart via 0x0E38
    doAcc('h0E38, 0, "R5"); doAcc('h31C7, 0, "R5"); doAcc('h03E0, 0, "R5");
    doAcc('h1234, 0, "R5 wrong addr");
    doAcc('h303F, 0, "R5"); doAcc('h0FC0, 0, "R5 no store");
    doAcc('h0E38, 0, "R5"); doAcc('h31C7, 0, "R5");
    prefix(0, "R5 restart");
    doAcc('h0FC0, 0, "R5 restart store");

    // repeated read
    doAcc('h0E38, 0, "R6"); doAcc('h31C7, 0, "R6");
    doAcc('h31C7, 0, "R6 repeat");
    doAcc('h03E0, 0, "R6"); doAcc('h3C1F, 0, "R6"); doAcc('h303F, 0, "R6");
    doAcc('h0FC0, 0, "R6 no store");
    doAcc('h0E38, 0, "R6"); doAcc('h0E38, 0, "R6 first repeat");
    for (int i = 1; i < 5; i++) doAcc(keyList[i], 0, "R6");
    doAcc('h0C63, 0, "R6 recall after first repeat");

    // bit 14 ignored
    prefix('h4000, "R7 prefix");
    doAcc('h4FC0, 0, "R7 store hi bit");

    // test sequence and idle after sixth
    prefix(0, "R8 prefix");
    doAcc('h339C, 0, "R8 test seq");
    prefix(0, "R8 prefix");
    doAcc('h0E38, 0, "R8 sixth 0E38");
    for (int i = 1; i < 5; i++) doAcc(keyList[i], 0, "R8");
    doAcc('h0FC0, 0, "R8 no store after idle");

    // gaps
    for (int i = 0; i < 5; i++) begin
      doAcc(keyList[i], 0, "R9 gapped");
      idleCyc(i + 1, "R9 gap");
    end
    doAcc('h0FC0, 0, "R9 store with gaps");

    // biased random stream
    for (int n = 0; n < 20000; n++) begin
      int r, a;
      bit wr;
      r = $urandom_range(0, 11);
      if (r < 5) a = keyList[r];
      else if (r == 5) a = 'h0FC0;
      else if (r == 6) a = 'h0C63;
      else if (r == 7) a = keyList[progress < 5 ? progress : 0];
      else if (r == 8) a = progress == 5 ? ($urandom_range(0,1) ? 'h0FC0 : 'h0C63)
                                         : keyList[progress];
      else a = $urandom_range(0, 'h3FFF);
      if ($urandom_range(0, 1)) a = a | 'h4000;
      wr = ($urandom_range(0, 19) == 0);
      if ($urandom_range(0, 7) == 0) idleCyc(1, "R9 random gap");
      else doAcc(a, wr, "R10 random");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule